// File: doc/BRIEF.md
# Static-Count Loop Sequencer

This block owns the program counter of an unpipelined machine that has no data-dependent branches. Each cycle in which an instruction completes, the PC either moves to the next address or, for the bounded-loop instruction, returns to the loop's start address. The trip count of every loop is written into the instruction itself, so the path the PC takes is fixed by the program and never by the data it handles. The PC therefore stays trusted, and its one-bit taint tag is tied to the trusted value.

The loop instruction names one of a small bank of down-counters. The first time it is reached, that counter is loaded from the instruction's count field and marked armed. Later encounters decrement it and jump back. When it runs out, the PC falls through to the next address and the counter returns to the unarmed state, so the same loop can be entered again later with a fresh load. A count of N runs the loop body N+1 times. The loop instruction ignores predicates.

Top module: `loop_seq`

## Requirements
- R1: During reset and in the first cycle after it, `pc` equals `RESET_PC` (default 0) and every counter slot is unarmed. A loop instruction reached right after reset performs a fresh load.
- R2: A cycle with `step_valid` low leaves `pc` and all counter state unchanged.
- R3: A valid step with `is_loop` low sets `pc` to `pc + 1` modulo 2^PC_W.
- R4: A valid loop instruction whose selected slot is unarmed and whose `loop_count` N is nonzero sets `pc` to `loop_target`, arms the slot, and leaves N-1 jumps remaining.
- R5: A valid loop instruction whose selected slot is armed with a nonzero number of remaining jumps sets `pc` to `loop_target` and lowers that number by one.
- R6: A valid loop instruction whose selected slot is armed with zero remaining jumps sets `pc` to `pc + 1` and returns the slot to unarmed. The next encounter reloads it from `loop_count`.
- R7: A valid loop instruction on an unarmed slot with `loop_count` equal to 0 sets `pc` to `pc + 1` and leaves the slot unarmed. The body runs exactly once.
- R8: The predicate input `pred_val` has no effect on `pc` or on counter state in any cycle.
- R9: Each of the `NUM_CTR` slots (default 8, chosen by `loop_sel`) keeps its own state, and a slot is not touched by instructions that select another slot. While a slot is armed, the `loop_count` field is ignored.
- R10: `pc_shadow` is 0 (trusted) in every cycle and never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | An instruction completes this cycle |
| is_loop | input | 1 | The completing instruction is the bounded-loop instruction |
| loop_sel | input | SEL_W | Counter slot named by the loop instruction |
| loop_count | input | CNT_W | Static jump count N of the loop instruction |
| loop_target | input | PC_W | Loop start address |
| pred_val | input | 1 | Current predicate value, ignored by this block |
| pc | output | PC_W | Program counter |
| pc_shadow | output | 1 | Taint tag of the PC, always trusted (0) |

## Verification
The assertions assume that `is_loop`, `loop_sel`, `loop_count` and `loop_target` are known whenever `step_valid` is high. They also assume that `loop_sel` is always below `NUM_CTR`. The bench drives every input with a defined value in every cycle. It draws `loop_sel` only from 0 to NUM_CTR-1. It toggles `pred_val` freely, because the block must not depend on it. Directed loops, nested loops on different slots, zero counts, reloads after exit and a PC wrap run first. A randomized stretch follows, in which a behavioural model checks the PC every cycle.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;

  // Action chosen for the PC each cycle
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,  // no instruction completes
    ACT_STEP = 2'd1,  // sequential advance (plain op or loop fall-through)
    ACT_JUMP = 2'd2   // back to loop start address
  } pc_act_e;

  // Command to the selected counter slot
  typedef enum logic [1:0] {
    CTR_KEEP  = 2'd0,
    CTR_LOAD  = 2'd1,
    CTR_DEC   = 2'd2,
    CTR_CLEAR = 2'd3
  } ctr_cmd_e;

endpackage

// File: rtl/lsq_ctr_bank.sv
module lsq_ctr_bank
  import loop_seq_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CNT_W   = 8,
  parameter int SEL_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  ctr_cmd_e         cmd,
  input  logic [CNT_W-1:0] load_cnt,
  output logic             sel_armed,
  output logic [CNT_W-1:0] sel_rem
);

  logic [NUM_CTR-1:0] armed_q;
  logic [CNT_W-1:0]   rem_q [NUM_CTR];

  // Remaining jumps after the first (jumping) encounter
  function automatic logic [CNT_W-1:0] first_rem(input logic [CNT_W-1:0] n);
    return n - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] dec_rem(input logic [CNT_W-1:0] r);
    return r - CNT_W'(1);
  endfunction

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
    logic hit;
    assign hit = (sel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        armed_q[i] <= 1'b0;
        rem_q[i]   <= '0;
      end else if (hit) begin
        unique case (cmd)
          CTR_LOAD: begin
            armed_q[i] <= 1'b1;
            rem_q[i]   <= first_rem(load_cnt);
          end
          CTR_DEC:   rem_q[i] <= dec_rem(rem_q[i]);
          CTR_CLEAR: begin
            armed_q[i] <= 1'b0;
            rem_q[i]   <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    sel_armed = 1'b0;
    sel_rem   = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (sel == SEL_W'(k)) begin
        sel_armed = armed_q[k];
        sel_rem   = rem_q[k];
      end
    end
  end

endmodule

// File: rtl/lsq_decide.sv
module lsq_decide
  import loop_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             step_valid,
  input  logic             is_loop,
  input  logic             sel_armed,
  input  logic [CNT_W-1:0] sel_rem,
  input  logic [CNT_W-1:0] load_cnt,
  output pc_act_e          act,
  output ctr_cmd_e         cmd,
  output logic             loop_fire,
  output logic             loop_take,
  output logic             loop_exit
);

  always_comb begin
    act       = ACT_HOLD;
    cmd       = CTR_KEEP;
    loop_take = 1'b0;
    loop_exit = 1'b0;
    loop_fire = step_valid && is_loop;
    if (step_valid) begin
      if (!is_loop) begin
        act = ACT_STEP;
      end else if (!sel_armed) begin
        if (load_cnt == '0) begin
          act       = ACT_STEP;   // body ran once; no load
          loop_exit = 1'b1;
        end else begin
          act       = ACT_JUMP;
          cmd       = CTR_LOAD;
          loop_take = 1'b1;
        end
      end else if (sel_rem == '0) begin
        act       = ACT_STEP;
        cmd       = CTR_CLEAR;
        loop_exit = 1'b1;
      end else begin
        act       = ACT_JUMP;
        cmd       = CTR_DEC;
        loop_take = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lsq_pc_reg.sv
module lsq_pc_reg
  import loop_seq_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pc_act_e         act,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);

  function automatic logic [PC_W-1:0] next_pc(input pc_act_e a,
                                              input logic [PC_W-1:0] cur,
                                              input logic [PC_W-1:0] tgt);
    unique case (a)
      ACT_STEP: return cur + PC_W'(1);
      ACT_JUMP: return tgt;
      default:  return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= RESET_PC;
    else        pc <= next_pc(act, pc, target);
  end

endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_seq_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter int              CNT_W    = 8,
  parameter int              NUM_CTR  = 8,
  parameter int              SEL_W    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic             is_loop,
  input  logic [SEL_W-1:0] loop_sel,
  input  logic [CNT_W-1:0] loop_count,
  input  logic [PC_W-1:0]  loop_target,
  input  logic             pred_val,
  output logic [PC_W-1:0]  pc,
  output logic             pc_shadow
);

  pc_act_e          act;
  ctr_cmd_e         cmd;
  logic             sel_armed;
  logic [CNT_W-1:0] sel_rem;
  logic             loop_fire;
  logic             loop_take;
  logic             loop_exit;
  logic             pred_unused;

  // The loop instruction is not predicable: the predicate never reaches the PC path
  assign pred_unused = pred_val;
  assign pc_shadow   = 1'b0;

  lsq_ctr_bank #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (loop_sel),
    .cmd      (cmd),
    .load_cnt (loop_count),
    .sel_armed(sel_armed),
    .sel_rem  (sel_rem)
  );

  lsq_decide #(.CNT_W(CNT_W)) u_decide (
    .step_valid(step_valid),
    .is_loop   (is_loop),
    .sel_armed (sel_armed),
    .sel_rem   (sel_rem),
    .load_cnt  (loop_count),
    .act       (act),
    .cmd       (cmd),
    .loop_fire (loop_fire),
    .loop_take (loop_take),
    .loop_exit (loop_exit)
  );

  lsq_pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .target(loop_target),
    .pc    (pc)
  );

endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step_valid,
  input logic            is_loop,
  input logic [PC_W-1:0] loop_target,
  input logic [PC_W-1:0] pc,
  input logic            pc_shadow,
  input logic            loop_fire,
  input logic            loop_take,
  input logic            loop_exit
);

  assert_pc_trusted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_shadow == 1'b0) && $stable(pc_shadow));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> $stable(pc));

  assert_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !is_loop) |=> (pc == $past(pc) + PC_W'(1)));

  assert_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_take |=> (pc == $past(loop_target)));

  assert_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit |=> (pc == $past(pc) + PC_W'(1)));

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_fire |-> ($countones({loop_take, loop_exit}) == 1));

  assert_no_stray_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_fire |-> !(loop_take || loop_exit));

endmodule

bind loop_seq loop_seq_chk #(.PC_W(PC_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_valid (step_valid),
  .is_loop    (is_loop),
  .loop_target(loop_target),
  .pc         (pc),
  .pc_shadow  (pc_shadow),
  .loop_fire  (loop_fire),
  .loop_take  (loop_take),
  .loop_exit  (loop_exit)
);

// File: tb/loop_seq_tb_top.sv
module loop_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16, CNT_W = 8, NUM_CTR = 8, SEL_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic step_valid = 1'b0, is_loop = 1'b0, pred_val = 1'b0;
  logic [SEL_W-1:0] loop_sel = '0;
  logic [CNT_W-1:0] loop_count = '0;
  logic [PC_W-1:0]  loop_target = '0;
  logic [PC_W-1:0]  pc;
  logic             pc_shadow;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural model
  int m_pc;
  bit m_armed [NUM_CTR];
  int m_rem   [NUM_CTR];

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_seq dut_i (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .is_loop(is_loop),
    .loop_sel(loop_sel), .loop_count(loop_count), .loop_target(loop_target),
    .pred_val(pred_val), .pc(pc), .pc_shadow(pc_shadow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = 0;
    for (int i = 0; i < NUM_CTR; i++) begin m_armed[i] = 0; m_rem[i] = 0; end
  endtask

  // One clock: drive on the falling edge, model, compare after the rising edge
  task automatic cyc(input bit v, input bit lp, input int sel, input int n,
                     input int tgt, input bit pr, input string req);
    @(negedge clk);
    step_valid = v; is_loop = lp; loop_sel = SEL_W'(sel);
    loop_count = CNT_W'(n); loop_target = PC_W'(tgt); pred_val = pr;
    if (v) begin
      if (!lp) m_pc = (m_pc + 1) % 65536;
      else if (!m_armed[sel]) begin
        if (n == 0) m_pc = (m_pc + 1) % 65536;
        else begin m_armed[sel] = 1; m_rem[sel] = n - 1; m_pc = tgt; end
      end else if (m_rem[sel] == 0) begin
        m_armed[sel] = 0; m_pc = (m_pc + 1) % 65536;
      end else begin
        m_rem[sel]--; m_pc = tgt;
      end
    end
    @(posedge clk); #1;
    check(req, int'(pc), m_pc);
    check("R10", int'(pc_shadow), 0);
  endtask

  task automatic body(input int len, input string req);
    for (int i = 0; i < len; i++) cyc(1, 0, 0, 0, 0, i[0], req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1 check("R1", int'(pc), 0);
    check("R10", int'(pc_shadow), 0);
    rst_n = 1'b1;

    // R2 hold, with other fields wiggling
    cyc(0, 1, 2, 5, 77, 1, "R2");
    cyc(0, 0, 0, 0, 0, 0, "R2");
    // R3 sequential
    body(3, "R3");
    // R1/R4 fresh load after reset, N=2: three bodies of length 2
    cyc(1, 1, 0, 2, 1, 0, "R4");
    body(2, "R3");
    cyc(1, 1, 0, 9, 1, 1, "R5");   // count field ignored while armed (R9)
    body(2, "R3");
    cyc(1, 1, 0, 2, 1, 0, "R6");
    // R6 re-entry reloads
    cyc(1, 1, 0, 1, 4, 1, "R6");
    body(1, "R3");
    cyc(1, 1, 0, 1, 4, 0, "R6");
    // R7 zero count falls through and stays unarmed
    cyc(1, 1, 3, 0, 50, 1, "R7");
    cyc(1, 1, 3, 1, 50, 0, "R7");
    cyc(1, 1, 3, 0, 50, 0, "R7");
    // R8 predicate ignored: same loop both predicate values
    cyc(1, 1, 4, 1, 20, 0, "R8");
    cyc(1, 1, 4, 1, 20, 1, "R8");
    cyc(1, 1, 4, 1, 20, 1, "R8");
    // R9 nested loops on slots 1 (outer) and 2 (inner)
    for (int o = 0; o < 3; o++) begin
      for (int k = 0; k < 3; k++) cyc(1, 1, 2, 2, 30, k[0], "R9");
      cyc(1, 1, 1, 2, 28, 0, "R9");
    end
    cyc(0, 0, 0, 0, 0, 0, "R2");
    // R3 wrap: jump to top address then step
    cyc(1, 1, 5, 1, 65535, 0, "R4");
    body(1, "R3");
    cyc(1, 1, 5, 1, 65535, 0, "R6");

    // randomized run against the model
    for (int i = 0; i < 600; i++) begin
      int s = $urandom_range(NUM_CTR - 1);
      cyc(($urandom_range(3) != 0), ($urandom_range(2) == 0), s,
          $urandom_range(3), $urandom_range(200), $urandom_range(1), "RND");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule